// File: doc/BRIEF.md
# Unified On-the-Fly AES-128 Round-Key Generator

This block supplies the round keys of AES-128 to a round-based cipher datapath, one key per clock cycle, without ever holding the expanded key schedule. It keeps a single 128-bit working key and a round-constant register. A load pulse captures a starting key and a direction. Each advance pulse then replaces the working key with its neighbour in the schedule.

For encryption the starting key is the cipher key, and each advance moves one round forward. For decryption the starting key is the final (round 10) key, which the user supplies, and each advance moves one round backward. Both directions run through one shared datapath. The substitution boxes, the round-constant register and the first-word update are common to both. The three XOR chains that rebuild the other words are kept separate for each direction, so that neither chain waits on the other.

Top module: `aes_ks_otf`

## Requirements
- R1: A cycle with `load_i` high copies `key_i` into the working key, and `rkey_o` shows it right after that clock edge, with no extra cycle.
- R2: After a cycle with `rst` high, `rkey_o` reads zero.
- R3: Word wK occupies bits [127-32K : 96-32K]. In forward mode an advance computes w0' = w0 ^ S(rot(w3)) ^ {rc,24'h0}, then w1' = w1^w0', w2' = w2^w1', w3' = w3^w2'. Here rot moves the top byte to the bottom and S substitutes each byte.
- R4: In backward mode an advance computes w3 = w3'^w2', w2 = w2'^w1', w1 = w1'^w0', and then w0 = w0' ^ S(rot(w3)) ^ {rc,24'h0}.
- R5: In forward mode rc starts at 8'h01 on load and is multiplied by x modulo 9'h11B after each advance, so ten advances from the cipher key reproduce the standard round-10 key.
- R6: In backward mode rc starts at 8'h36 on load and is divided by x modulo 9'h11B after each advance, so ten advances from the round-10 key return the cipher key.
- R7: With `load_i` and `advance_i` both low, the working key does not change.
- R8: When `load_i` and `advance_i` are both high, the load wins and `rkey_o` shows `key_i`.
- R9: The direction is sampled only at load (`decrypt_i`=1 means backward). Changing `decrypt_i` between loads has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Capture `key_i` and `decrypt_i` |
| decrypt_i | input | 1 | Direction at load: 0 forward, 1 backward |
| key_i | input | 128 | Starting key (cipher key, or round-10 key for backward) |
| advance_i | input | 1 | Step the working key one round |
| rkey_o | output | 128 | Current round key |

## Verification
The bench expands each key with its own model, using a substitution box built by brute-force inversion. It compares every round in both directions, for the published test key and for random keys. A round constant that starts wrong, or that is stepped the wrong way, already breaks round 1, or round 9 going backward. A backward step that fed the substitution from the old w3 instead of the rebuilt one would give wrong first words from the first step. The bench also goes after the priority of load over advance and a direction input that toggles between loads. A design that got these wrong would show the previous key, or would step in the wrong direction.

// File: rtl/aes_ks_pkg.sv
package aes_ks_pkg;

    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 4 * BYTE_W;
    localparam int NWORDS  = 4;
    localparam int KEY_W   = NWORDS * WORD_W;
    localparam logic [BYTE_W:0] GF_POLY   = 9'h11B;
    localparam logic [BYTE_W-1:0] AFF_C   = 8'h63;
    localparam logic [BYTE_W-1:0] RC_FWD0 = 8'h01;
    localparam logic [BYTE_W-1:0] RC_BWD0 = 8'h36;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t w0;
        word_t w1;
        word_t w2;
        word_t w3;
    } key_t;

    typedef enum logic {DIR_FWD = 1'b0, DIR_BWD = 1'b1} dir_e;

    function automatic byte_t gf_dbl(byte_t a);
        gf_dbl = {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? GF_POLY[BYTE_W-1:0] : '0);
    endfunction

    function automatic byte_t gf_half(byte_t a);
        logic [BYTE_W:0] t;
        t = a[0] ? ({1'b0, a} ^ GF_POLY) : {1'b0, a};
        gf_half = t[BYTE_W:1];
    endfunction

    function automatic byte_t gf_mul(byte_t a, byte_t b);
        byte_t p, s;
        p = '0;
        s = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) p = p ^ s;
            s = gf_dbl(s);
        end
        gf_mul = p;
    endfunction

    // a^254 is the multiplicative inverse, and maps 0 to 0
    function automatic byte_t gf_inv(byte_t a);
        byte_t sq, acc;
        sq  = a;
        acc = 8'h01;
        for (int i = 1; i < BYTE_W; i++) begin
            sq  = gf_mul(sq, sq);
            acc = gf_mul(acc, sq);
        end
        gf_inv = acc;
    endfunction

    function automatic byte_t rotl8(byte_t x, int n);
        rotl8 = (x << n) | (x >> (BYTE_W - n));
    endfunction

    function automatic byte_t sbox_affine(byte_t b);
        byte_t r;
        r = b;
        for (int k = 1; k <= 4; k++) r = r ^ rotl8(b, k);
        sbox_affine = r ^ AFF_C;
    endfunction

    function automatic word_t rot_word(word_t w);
        rot_word = {w[WORD_W-BYTE_W-1:0], w[WORD_W-1:WORD_W-BYTE_W]};
    endfunction

endpackage

// File: rtl/ks_sbox.sv
module ks_sbox
    import aes_ks_pkg::*;
(
    input  byte_t in_b,
    output byte_t out_b
);
    byte_t inv_b;
    assign inv_b = gf_inv(in_b);
    assign out_b = sbox_affine(inv_b);
endmodule

// File: rtl/ks_rcon.sv
module ks_rcon
    import aes_ks_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load_i,
    input  logic  bwd_load_i,
    input  logic  adv_i,
    input  dir_e  dir_q_i,
    output byte_t rc_o
);
    byte_t rc_q;

    always_ff @(posedge clk) begin
        if (rst)            rc_q <= RC_FWD0;
        else if (load_i)    rc_q <= bwd_load_i ? RC_BWD0 : RC_FWD0;
        else if (adv_i)     rc_q <= (dir_q_i == DIR_BWD) ? gf_half(rc_q) : gf_dbl(rc_q);
    end

    assign rc_o = rc_q;

    // R5
    rc_fwd_start_chk: assert property (@(posedge clk) disable iff (rst)
        (load_i && !bwd_load_i) |=> (rc_q == RC_FWD0));
    // R6
    rc_bwd_start_chk: assert property (@(posedge clk) disable iff (rst)
        (load_i && bwd_load_i) |=> (rc_q == RC_BWD0));
    // R5
    rc_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        rc_q != '0);
endmodule

// File: rtl/ks_step.sv
module ks_step
    import aes_ks_pkg::*;
(
    input  key_t  cur_i,
    input  dir_e  dir_i,
    input  byte_t rc_i,
    output key_t  nxt_o
);
    // forward chain copy
    word_t f1, f2, f3;
    // backward chain copy (kept apart for depth)
    word_t b1, b2, b3;
    word_t sub_in, sub_out, w0_new;

    assign b3 = cur_i.w3 ^ cur_i.w2;
    assign b2 = cur_i.w2 ^ cur_i.w1;
    assign b1 = cur_i.w1 ^ cur_i.w0;

    // shared substitution: both directions feed the freshly final last word
    assign sub_in = rot_word((dir_i == DIR_BWD) ? b3 : cur_i.w3);

    for (genvar g = 0; g < NWORDS; g++) begin : g_sub
        ks_sbox u_sb (
            .in_b  (sub_in[g*BYTE_W +: BYTE_W]),
            .out_b (sub_out[g*BYTE_W +: BYTE_W])
        );
    end

    assign w0_new = cur_i.w0 ^ sub_out ^ {rc_i, {(WORD_W-BYTE_W){1'b0}}};

    assign f1 = cur_i.w1 ^ w0_new;
    assign f2 = cur_i.w2 ^ f1;
    assign f3 = cur_i.w3 ^ f2;

    always_comb begin
        if (dir_i == DIR_BWD) nxt_o = '{w0: w0_new, w1: b1, w2: b2, w3: b3};
        else                  nxt_o = '{w0: w0_new, w1: f1, w2: f2, w3: f3};
    end
endmodule

// File: rtl/aes_ks_otf.sv
module aes_ks_otf
    import aes_ks_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic             decrypt_i,
    input  logic [KEY_W-1:0] key_i,
    input  logic             advance_i,
    output logic [KEY_W-1:0] rkey_o
);
    key_t  key_q, key_nxt;
    dir_e  dir_q;
    byte_t rc;

    ks_rcon u_rcon (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load_i),
        .bwd_load_i (decrypt_i),
        .adv_i      (advance_i),
        .dir_q_i    (dir_q),
        .rc_o       (rc)
    );

    ks_step u_step (
        .cur_i (key_q),
        .dir_i (dir_q),
        .rc_i  (rc),
        .nxt_o (key_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            key_q <= '0;
            dir_q <= DIR_FWD;
        end else if (load_i) begin
            key_q <= key_t'(key_i);
            dir_q <= decrypt_i ? DIR_BWD : DIR_FWD;
        end else if (advance_i) begin
            key_q <= key_nxt;
        end
    end

    assign rkey_o = key_q;

    // R1
    load_capture_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (rkey_o == $past(key_i)));
    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !advance_i) |=> $stable(rkey_o));
    // R9
    dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(dir_q));
    // R3
    fwd_chain_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_i && advance_i && dir_q == DIR_FWD) |=>
        (key_q.w3 == ($past(key_q.w3) ^ key_q.w2)));
    // R4
    bwd_chain_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_i && advance_i && dir_q == DIR_BWD) |=>
        (key_q.w1 == ($past(key_q.w1) ^ $past(key_q.w0))));
endmodule

// File: tb/aes_ks_otf_test.sv
module aes_ks_otf_test;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst, load_i, decrypt_i, advance_i;
    logic [127:0] key_i, rkey_o;
    int checks = 0, failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    aes_ks_otf uut (
        .clk(clk), .rst(rst), .load_i(load_i), .decrypt_i(decrypt_i),
        .key_i(key_i), .advance_i(advance_i), .rkey_o(rkey_o)
    );

    // ---- independent reference model ----
    function automatic logic [7:0] m_x2(logic [7:0] a);
        return a[7] ? ((a << 1) ^ 8'h1B) : (a << 1);
    endfunction
    function automatic logic [7:0] m_mul(logic [7:0] a, logic [7:0] b);
        logic [7:0] p = 0;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p ^= a;
            a = m_x2(a);
        end
        return p;
    endfunction
    function automatic logic [7:0] m_sbox(logic [7:0] x);
        logic [7:0] inv = 0, s;
        for (int y = 1; y < 256; y++)
            if (m_mul(x, 8'(y)) == 8'h01) inv = 8'(y);
        s = inv ^ {inv[6:0],inv[7]} ^ {inv[5:0],inv[7:6]} ^ {inv[4:0],inv[7:5]} ^ {inv[3:0],inv[7:4]} ^ 8'h63;
        return s;
    endfunction

    logic [127:0] rk [11];
    logic [7:0]   sb [256];

    task automatic expand(input logic [127:0] k);
        logic [31:0] w [44];
        logic [31:0] t;
        logic [7:0]  rc = 8'h01;
        for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            t = w[i-1];
            if (i % 4 == 0) begin
                t = {t[23:0], t[31:24]};
                t = {sb[t[31:24]], sb[t[23:16]], sb[t[15:8]], sb[t[7:0]]} ^ {rc, 24'h0};
                rc = m_x2(rc);
            end
            w[i] = w[i-4] ^ t;
        end
        for (int r = 0; r < 11; r++) rk[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
    endtask

    task automatic chk(input string req, input logic [127:0] exp);
        checks++;
        if (rkey_o !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, rkey_o, exp);
        end
    endtask

    task automatic do_load(input logic [127:0] k, input logic dec, input logic adv);
        load_i = 1; decrypt_i = dec; key_i = k; advance_i = adv;
        @(negedge clk);
        load_i = 0; advance_i = 0;
    endtask

    task automatic do_adv();
        advance_i = 1;
        @(negedge clk);
        advance_i = 0;
    endtask

    task automatic run_both(input logic [127:0] k);
        expand(k);
        do_load(k, 1'b0, 1'b0);
        chk("R1 fwd start", rk[0]);
        for (int r = 1; r <= 10; r++) begin
            do_adv();
            chk("R3 R5 fwd round", rk[r]);
        end
        do_load(rk[10], 1'b1, 1'b0);
        chk("R1 bwd start", rk[10]);
        for (int r = 9; r >= 0; r--) begin
            do_adv();
            chk("R4 R6 bwd round", rk[r]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [127:0] k;
        for (int i = 0; i < 256; i++) sb[i] = m_sbox(8'(i));
        void'($urandom(32'h1A2B3C4D));
        rst = 1; load_i = 0; decrypt_i = 0; advance_i = 1; key_i = '1;
        repeat (3) @(negedge clk);
        chk("R2 reset", 128'h0);
        rst = 0; advance_i = 0;

        // published vector
        run_both(128'h2b7e151628aed2a6abf7158809cf4f3c);
        expand(128'h2b7e151628aed2a6abf7158809cf4f3c);
        do_load(rk[0], 1'b0, 1'b0);
        for (int r = 1; r <= 10; r++) do_adv();
        chk("R5 known round10", 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);

        // R7 idle hold
        repeat (3) @(negedge clk);
        chk("R7 idle hold", 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);

        // R8 load beats advance
        do_load(128'h00112233445566778899aabbccddeeff, 1'b0, 1'b1);
        chk("R8 load priority", 128'h00112233445566778899aabbccddeeff);

        // R9 decrypt_i toggled after forward load
        k = 128'h000102030405060708090a0b0c0d0e0f;
        expand(k);
        do_load(k, 1'b0, 1'b0);
        decrypt_i = 1;
        for (int r = 1; r <= 3; r++) begin
            do_adv();
            chk("R9 dir ignored fwd", rk[r]);
        end
        do_load(rk[10], 1'b1, 1'b0);
        decrypt_i = 0;
        do_adv();
        chk("R9 dir ignored bwd", rk[9]);
        // reload mid-run restarts constant
        do_load(k, 1'b0, 1'b0);
        do_adv();
        chk("R5 reload restarts rc", rk[1]);

        // random keys
        for (int n = 0; n < 6; n++) begin
            k = {$urandom, $urandom, $urandom, $urandom};
            run_both(k);
        end
        k = '0;
        run_both(k);
        k = '1;
        run_both(k);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule